// File: doc/BRIEF.md
# Radix-4 Recoded Signed Multiplier

This block multiplies two N-bit two's-complement numbers and returns the full 2N-bit signed product. The multiplier operand is scanned in overlapping three-bit windows. Each window is two new bits plus the bit just below them, and a zero stands in below the least significant bit. Each window maps to one digit from the set {-2, -1, 0, +1, +2}, so an N-bit multiplier yields only N/2 summands. Negative multipliers need no complementing before the scan.

Each digit picks a multiple of the multiplicand. The multiple is widened with its sign to 2N bits, negated in two's complement when the digit is negative, and moved up by two bit places for each window position. The summands are then added into the product.

The block is a three-register pipeline. It takes one operand pair on any cycle where `in_valid` is high, and returns the matching product with `out_valid` a fixed number of cycles later. Between results the product output keeps its last value.

Top module: `bp_pair_mul`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0 and `out_prod` is all zeros.
- R2: For every pair of N-bit two's-complement operands, `out_prod` equals the exact signed product as a 2N-bit two's-complement value.
- R3: `out_valid` rises after the third rising clock edge, counting the edge that samples `in_valid` high, and it is high for exactly one cycle per accepted pair.
- R4: Window k holds multiplier bits 2k+1, 2k and 2k-1, with bit -1 taken as 0. The windows map to digits as follows: 000 and 111 give 0; 001 and 010 give +1; 011 gives +2; 100 gives -2; 101 and 110 give -1. The digits weighted by 4^k add up to the signed multiplier, so a multiplicand of 1 returns the multiplier sign-extended to 2N bits.
- R5: 13 times -6 gives -78. The recoded digits of -6 are -2, -1, 0, listed from the lowest window up.
- R6: Operands at the extremes give exact results: (-2^(N-1)) squared is +2^(2N-2), and (-2^(N-1)) times (2^(N-1)-1) is negative.
- R7: On cycles when no result is due, `out_prod` keeps the last delivered product.
- R8: A new pair may be presented on every cycle, and back-to-back pairs each give their own product in order.
- R9: A zero multiplicand or a zero multiplier gives a product of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_mcand | input | N | Multiplicand, two's complement |
| in_mplier | input | N | Multiplier, two's complement |
| out_valid | output | 1 | Product present this cycle |
| out_prod | output | 2N | Signed product, two's complement |

## Verification
A product is due three rising edges after its pair is sampled. The edges are the operand register, the summand register and the product register. The bench drives inputs one nanosecond after a rising edge. It pushes each expected valid flag and product through its own three-deep model clocked on the same edges, and compares the outputs at the falling edge. That model updates its held product only when a result is due, so idle cycles check the hold rule. Phases cover the worked 13 by -6 case, the extreme operands, zero operands, a multiplicand of one over every multiplier, and a back-to-back sweep over all 65,536 pairs for N = 8.

// File: rtl/bp_mul_pkg.sv
package bp_mul_pkg;

  // Recoded digit: nz = non-zero, neg = negative, dbl = magnitude two
  typedef struct packed {
    logic nz;
    logic neg;
    logic dbl;
  } bp_digit_t;

  function automatic logic signed [2:0] bp_digit_val(bp_digit_t d);
    logic signed [2:0] mag;
    if (!d.nz) return 3'sd0;
    mag = d.dbl ? 3'sd2 : 3'sd1;
    return d.neg ? -mag : mag;
  endfunction

endpackage

// File: rtl/bp_recoder.sv
module bp_recoder
  import bp_mul_pkg::*;
(
  input  logic [2:0] trip,
  output bp_digit_t  dig
);
  always_comb begin
    dig.nz  = !(trip == 3'b000 || trip == 3'b111);
    dig.dbl = (trip == 3'b011) || (trip == 3'b100);
    dig.neg = trip[2] & dig.nz;
  end
endmodule

// File: rtl/bp_summand.sv
module bp_summand
  import bp_mul_pkg::*;
#(
  parameter int N     = 8,
  parameter int SHIFT = 0
) (
  input  logic [N-1:0]   mcand,
  input  bp_digit_t      dig,
  output logic [2*N-1:0] summand
);
  localparam int W = 2 * N;

  logic [W-1:0] m_ext, mag, sgn;

  always_comb begin
    m_ext   = {{N{mcand[N-1]}}, mcand};
    mag     = dig.dbl ? (m_ext << 1) : m_ext;
    sgn     = dig.neg ? (~mag + W'(1)) : mag;
    summand = dig.nz ? (sgn << SHIFT) : '0;
  end
endmodule

// File: rtl/bp_acc.sv
module bp_acc #(
  parameter int W = 16,
  parameter int G = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [G-1:0][W-1:0] summ,
  output logic [W-1:0]        acc
);
  logic [W-1:0] total;

  always_comb begin
    total = '0;
    for (int g = 0; g < G; g++) total = total + summ[g];
  end

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= total;
  end
endmodule

// File: rtl/bp_pair_mul.sv
module bp_pair_mul
  import bp_mul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N-1:0]   in_mcand,
  input  logic [N-1:0]   in_mplier,
  output logic           out_valid,
  output logic [2*N-1:0] out_prod
);
  localparam int W = 2 * N;
  localparam int G = N / 2;

  if ((N % 2) != 0 || N < 2) begin : g_bad_n
    $error("bp_pair_mul: N must be even and at least 2");
  end

  // Stage A: operand register
  logic         vld_a;
  logic [N-1:0] m_a, q_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_a <= 1'b0;
      m_a   <= '0;
      q_a   <= '0;
    end else begin
      vld_a <= in_valid;
      if (in_valid) begin
        m_a <= in_mcand;
        q_a <= in_mplier;
      end
    end
  end

  // Recoding and summand forming
  logic [N:0]          q_ext;
  bp_digit_t           dig [G];
  logic [G-1:0][W-1:0] summ_d;

  assign q_ext = {q_a, 1'b0};

  for (genvar g = 0; g < G; g++) begin : g_win
    bp_recoder u_rec (
      .trip (q_ext[2*g+2 -: 3]),
      .dig  (dig[g])
    );
    bp_summand #(.N(N), .SHIFT(2*g)) u_smd (
      .mcand   (m_a),
      .dig     (dig[g]),
      .summand (summ_d[g])
    );
  end

  // Stage B: summand register
  logic                vld_b;
  logic [G-1:0][W-1:0] summ_b;
  logic [N-1:0]        m_b, q_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_b  <= 1'b0;
      summ_b <= '0;
      m_b    <= '0;
      q_b    <= '0;
    end else begin
      vld_b <= vld_a;
      if (vld_a) begin
        summ_b <= summ_d;
        m_b    <= m_a;
        q_b    <= q_a;
      end
    end
  end

  // Stage C: accumulation into product register
  bp_acc #(.W(W), .G(G)) u_acc (
    .clk  (clk),
    .rst  (rst),
    .en   (vld_b),
    .summ (summ_b),
    .acc  (out_prod)
  );

  logic [N-1:0] m_c, q_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      m_c       <= '0;
      q_c       <= '0;
    end else begin
      out_valid <= vld_b;
      if (vld_b) begin
        m_c <= m_b;
        q_c <= q_b;
      end
    end
  end

  // ---------------- assertions ----------------
  logic [1:0]   rcyc;
  logic [W-1:0] recon, q_sx, ref_prod, mc_x, qc_x;

  always_ff @(posedge clk) begin
    if (rst)              rcyc <= '0;
    else if (rcyc != 2'd3) rcyc <= rcyc + 2'd1;
  end

  always_comb begin
    recon = '0;
    for (int k = 0; k < G; k++) begin
      recon = recon + ({{(W-3){bp_digit_val(dig[k])[2]}}, bp_digit_val(dig[k])} << (2*k));
    end
    q_sx     = {{N{q_a[N-1]}}, q_a};
    mc_x     = {{N{m_c[N-1]}}, m_c};
    qc_x     = {{N{q_c[N-1]}}, q_c};
    ref_prod = mc_x * qc_x;
  end

  // R4
  recode_sum_chk: assert property (@(posedge clk) disable iff (rst)
    vld_a |-> (recon == q_sx));

  // R2
  product_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_prod == ref_prod));

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (rcyc == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R9
  zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (m_c == '0 || q_c == '0)) |-> (out_prod == '0));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!vld_b && !rst) |=> $stable(out_prod));

endmodule

// File: tb/bp_pair_mul_test.sv
`timescale 1ns/1ps
module bp_pair_mul_test;
  localparam int NB = 8;
  localparam int W  = 2 * NB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [NB-1:0] in_mcand = '0;
  logic [NB-1:0] in_mplier = '0;
  logic          out_valid;
  logic [W-1:0]  out_prod;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  bit    chk_on = 1'b0;
  string in_tag = "R2";

  always #2 clk = ~clk;   // 250 MHz

  bp_pair_mul #(.N(NB)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_mcand(in_mcand), .in_mplier(in_mplier),
    .out_valid(out_valid), .out_prod(out_prod)
  );

  function automatic logic [W-1:0] ref_mul(logic [NB-1:0] a, logic [NB-1:0] b);
    longint pa, pb, pr;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    pr = pa * pb;
    return pr[W-1:0];
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected-result pipeline: three edges from sampling to output
  logic         ev0, ev1, ev2;
  logic [W-1:0] ep0, ep1, ep2;
  string        et0, et1, et2;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      ev0 <= 1'b0; ev1 <= 1'b0; ev2 <= 1'b0;
      ep2 <= '0;
    end else begin
      ev0 <= in_valid; ep0 <= ref_mul(in_mcand, in_mplier); et0 <= in_tag;
      ev1 <= ev0;      ep1 <= ep0; et1 <= et0;
      ev2 <= ev1;
      if (ev1) begin ep2 <= ep1; et2 <= et1; end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      check("R3 valid timing", W'(out_valid), W'(ev2));
      if (ev2) check(et2, out_prod, ep2);
      else     check("R7 hold", out_prod, ep2);
    end
  end

  task automatic drive(logic [NB-1:0] a, logic [NB-1:0] b, string tag);
    @(posedge clk); #1;
    in_valid = 1'b1; in_mcand = a; in_mplier = b; in_tag = tag;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_mcand = 8'hA5; in_mplier = 8'h3C;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 200000) begin
      n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected under 200000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 reset valid", W'(out_valid), '0);
    check("R1 reset product", out_prod, '0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check("R1 post-reset valid", W'(out_valid), '0);
    check("R1 post-reset product", out_prod, '0);
    chk_on = 1'b1;

    // R5: worked example, then idle cycles exercise hold (R7)
    drive(8'd13, 8'hFA, "R5 13 x -6");
    idle(6);

    // R6: extreme operands
    drive(8'h80, 8'h80, "R6 min x min");
    drive(8'h80, 8'h7F, "R6 min x max");
    drive(8'h7F, 8'h80, "R6 max x min");
    drive(8'h7F, 8'h7F, "R6 max x max");
    drive(8'hFF, 8'h80, "R6 -1 x min");
    idle(4);

    // R9: zero operands
    drive(8'h00, 8'h80, "R9 zero mcand");
    drive(8'h80, 8'h00, "R9 zero mplier");
    drive(8'h00, 8'h00, "R9 both zero");
    idle(2);
    drive(8'h55, 8'h00, "R9 zero mplier after gap");
    idle(4);

    // R4: unit multiplicand returns each multiplier sign-extended
    for (int q = 0; q < (1 << NB); q++) begin
      drive(8'h01, NB'(q), "R4 recode unit");
      if (q % 37 == 0) idle(1);
    end
    idle(4);

    // R2 and R8: all pairs back to back
    for (int a = 0; a < (1 << NB); a++)
      for (int b = 0; b < (1 << NB); b++)
        drive(NB'(a), NB'(b), "R2 R8 sweep");
    idle(6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule